// File: doc/BRIEF.md
# Parallel Fetch-Line Instruction Aligner

The aligner sits between an instruction fetch buffer and a bank of parallel decoders. Each cycle it receives one fetch line of `NPARC` 16-bit parcels. The line can mix 16-bit compressed instructions and 32-bit instructions. A start offset names the parcel where the first instruction of interest begins. The aligner hands each decoder slot a 32-bit window that starts on that slot's own instruction boundary. It also reports whether the instruction in the slot is compressed.

A parcel opens a compressed instruction when its two low bits are anything other than `11`. Where slot k begins depends on how many earlier instructions were compressed. A serial walk through the slots would grow in delay with each slot. Instead, the aligner builds a table of single-instruction steps for every parcel position. It then squares that table level by level, in the manner of a lookahead adder, so that each slot's start is found in a logarithmic number of selection stages.

A 32-bit instruction that begins on the last parcel cannot be completed from this line, so it is not issued. The aligner reports where the caller must resume and how many slots hold instructions. All results are registered.

Top module: `fetch_aligner`

## Requirements
- R1: A parcel is compressed exactly when its bits [1:0] are not `2'b11`. For each valid slot, `cmp_o[k]` is 1 when the slot's first parcel is compressed.
- R2: When its start parcel lies inside the line, slot 0 begins at parcel `start_off`.
- R3: Slot k+1 begins one parcel after slot k when slot k is compressed, and two parcels after it otherwise.
- R4: The window of slot k is `win_o[32k+31:32k]`. For a valid 32-bit slot that begins at parcel p, the low half is parcel p and the high half is parcel p+1. For a valid compressed slot, the low half is parcel p and the high half is zero.
- R5: A slot is valid when its start parcel is below `NPARC` and its whole instruction fits in the line. A 32-bit instruction that begins on parcel `NPARC-1` is not issued.
- R6: Valid slots form a contiguous run from slot 0, and `cnt_o` equals the number of valid slots.
- R7: `resume_o` is `NPARC-1` when a 32-bit instruction straddles the line end, and `NPARC` otherwise.
- R8: An invalid slot has a zero window and a zero compressed flag.
- R9: Outputs change on the clock edge that samples `line_vld` high, one cycle after the input. A cycle with `line_vld` low yields all-zero outputs on the next edge.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_vld | input | 1 | Fetch line present this cycle |
| line_in | input | NPARC*16 | Fetch line; parcel i occupies bits [16i+15:16i] |
| start_off | input | $clog2(NPARC) | Parcel index of the first instruction |
| win_o | output | NPARC*32 | Per-slot 32-bit instruction windows |
| vld_o | output | NPARC | Per-slot valid bits |
| cmp_o | output | NPARC | Per-slot compressed flags |
| cnt_o | output | $clog2(NPARC+1) | Number of instructions issued |
| resume_o | output | $clog2(NPARC+1) | Parcel at which fetching resumes |

## Verification
Every result of the aligner (windows, valid bits, flags, count and resume offset) appears on the clock edge that samples the line, one register stage later. The bench changes inputs on the falling edge and reads outputs one time unit after the next rising edge. That reading therefore always belongs to the line driven just before that edge.

To confirm the single-cycle latency, the bench also reads the outputs right after driving a new input and before the edge. At that point it expects the previous line's results to be unchanged. The idle case is checked one edge after `line_vld` drops.

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int NPARC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_vld,
  input  logic [NPARC*16-1:0]        line_in,
  input  logic [$clog2(NPARC)-1:0]   start_off,
  output logic [NPARC*32-1:0]        win_o,
  output logic [NPARC-1:0]           vld_o,
  output logic [NPARC-1:0]           cmp_o,
  output logic [$clog2(NPARC+1)-1:0] cnt_o,
  output logic [$clog2(NPARC+1)-1:0] resume_o
);
  localparam int NS = NPARC + 2;
  localparam int PW = $clog2(NS);
  localparam int LV = $clog2(NPARC + 1);
  localparam int CW = $clog2(NPARC + 1);
  localparam logic [PW-1:0] NP = PW'(NPARC);

  logic [NS-1:0] shp;
  logic [15:0]   par [NS+1];

  genvar gi, gl, gk;
  generate
    for (gi = 0; gi < NS + 1; gi++) begin : g_par
      if (gi < NPARC) begin : g_real
        assign par[gi] = line_in[16*gi +: 16];
        assign shp[gi] = line_in[16*gi +: 2] != 2'b11;
      end else begin : g_pad
        assign par[gi] = '0;
        if (gi < NS) begin : g_flag
          assign shp[gi] = 1'b0;
        end
      end
    end

    for (gl = 0; gl < LV; gl++) begin : g_lv
      logic [PW-1:0] j [NS];
      if (gl == 0) begin : g_base
        always_comb
          for (int i = 0; i < NS; i++)
            j[i] = (i < NPARC) ? PW'(i) + (shp[i] ? PW'(1) : PW'(2)) : PW'(i);
      end else begin : g_sq
        always_comb
          for (int i = 0; i < NS; i++)
            j[i] = g_lv[gl-1].j[g_lv[gl-1].j[i]];
      end
    end

    for (gk = 0; gk <= NPARC; gk++) begin : g_pos
      logic [PW-1:0] q [LV+1];
      assign q[0] = PW'(start_off);
      for (gl = 0; gl < LV; gl++) begin : g_step
        if (((gk >> gl) & 1) == 1) begin : g_take
          assign q[gl+1] = g_lv[gl].j[q[gl]];
        end else begin : g_skip
          assign q[gl+1] = q[gl];
        end
      end
    end
  endgenerate

  logic [NPARC*32-1:0] win_n;
  logic [NPARC-1:0]    vld_n, cmp_n;
  logic [CW-1:0]       cnt_n, resume_n;

  generate
    for (gk = 0; gk < NPARC; gk++) begin : g_slot
      logic [PW-1:0] p;
      assign p = g_pos[gk].q[LV];
      assign vld_n[gk] = (p < NP) && (g_lv[0].j[p] <= NP);
      assign cmp_n[gk] = vld_n[gk] && shp[p];
      assign win_n[32*gk +: 32] = !vld_n[gk] ? 32'h0 :
                                  cmp_n[gk]  ? {16'h0, par[p]} :
                                               {par[p + PW'(1)], par[p]};
    end
  endgenerate

  always_comb begin
    cnt_n = '0;
    for (int i = 0; i < NPARC; i++) cnt_n = cnt_n + CW'(vld_n[i]);
  end

  assign resume_n = (g_pos[NPARC].q[LV] == NP + PW'(1)) ? CW'(NPARC - 1) : CW'(NPARC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o    <= '0;
      vld_o    <= '0;
      cmp_o    <= '0;
      cnt_o    <= '0;
      resume_o <= '0;
    end else if (line_vld) begin
      win_o    <= win_n;
      vld_o    <= vld_n;
      cmp_o    <= cmp_n;
      cnt_o    <= cnt_n;
      resume_o <= resume_n;
    end else begin
      win_o    <= '0;
      vld_o    <= '0;
      cmp_o    <= '0;
      cnt_o    <= '0;
      resume_o <= '0;
    end
  end
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
  parameter int NPARC = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       line_vld,
  input logic [NPARC*16-1:0]        line_in,
  input logic [$clog2(NPARC)-1:0]   start_off,
  input logic [NPARC*32-1:0]        win_o,
  input logic [NPARC-1:0]           vld_o,
  input logic [NPARC-1:0]           cmp_o,
  input logic [$clog2(NPARC+1)-1:0] cnt_o,
  input logic [$clog2(NPARC+1)-1:0] resume_o
);
  localparam int CW = $clog2(NPARC + 1);

  logic short_hi_bad;
  always_comb begin
    short_hi_bad = 1'b0;
    for (int k = 0; k < NPARC; k++)
      if (vld_o[k] && cmp_o[k] && win_o[32*k+16 +: 16] != 16'h0) short_hi_bad = 1'b1;
  end

  // R6
  contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o & (vld_o + 1'b1)) == '0);

  // R6
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_o) == int'(cnt_o));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |=> (vld_o == '0 && cnt_o == '0));

  // R2
  slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && start_off == '0) |=> (vld_o[0] && win_o[15:0] == $past(line_in[15:0])));

  // R1
  flag0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && start_off == '0) |=> (cmp_o[0] == ($past(line_in[1:0]) != 2'b11)));

  // R8
  cmp_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_o & ~vld_o) == '0);

  // R4
  short_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !short_hi_bad);

  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld |=> (resume_o == CW'(NPARC) || resume_o == CW'(NPARC - 1)));
endmodule

bind fetch_aligner fetch_aligner_chk #(.NPARC(NPARC)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_in(line_in),
  .start_off(start_off), .win_o(win_o), .vld_o(vld_o), .cmp_o(cmp_o),
  .cnt_o(cnt_o), .resume_o(resume_o)
);

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
  localparam int CLK_P = 10;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int SW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_vld = 1'b0;
  logic [N*16-1:0] line_in = '0;
  logic [SW-1:0]   start_off = '0;
  logic [N*32-1:0] win_o;
  logic [N-1:0]    vld_o, cmp_o;
  logic [CW-1:0]   cnt_o, resume_o;

  fetch_aligner #(.NPARC(N)) uut (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_in(line_in),
    .start_off(start_off), .win_o(win_o), .vld_o(vld_o), .cmp_o(cmp_o),
    .cnt_o(cnt_o), .resume_o(resume_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int errs = 0, checks = 0;
  logic [31:0]     lcg = 32'h1234_5678;
  logic [N*32-1:0] ewin;
  logic [N-1:0]    evld, ecmp;
  logic [CW-1:0]   ecnt, eres;

  task automatic chk(input string tag, input logic [N*32-1:0] act, input logic [N*32-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [N-1:0] pat);
    for (int i = 0; i < N; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      line_in[16*i +: 16] = {lcg[31:18], pat[i] ? ((lcg[17:16] == 2'b11) ? 2'b01 : lcg[17:16]) : 2'b11};
    end
  endtask

  task automatic model(input int st);
    int  p;
    bit  strad;
    p = st; strad = 0;
    ewin = '0; evld = '0; ecmp = '0; ecnt = '0;
    for (int k = 0; k < N; k++) begin
      if (p < N && !strad) begin
        if (line_in[16*p +: 2] != 2'b11) begin
          evld[k] = 1'b1; ecmp[k] = 1'b1;
          ewin[32*k +: 32] = {16'h0, line_in[16*p +: 16]};
          p = p + 1; ecnt = ecnt + 1'b1;
        end else if (p + 1 < N) begin
          evld[k] = 1'b1;
          ewin[32*k +: 32] = {line_in[16*(p+1) +: 16], line_in[16*p +: 16]};
          p = p + 2; ecnt = ecnt + 1'b1;
        end else strad = 1;
      end
    end
    eres = strad ? CW'(N - 1) : CW'(N);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 win", win_o, '0);
    chk("R10 vld", N*32'(vld_o), '0);
    chk("R10 cnt", N*32'(cnt_o), '0);
    chk("R10 resume", N*32'(resume_o), '0);
    @(negedge clk) rst_n = 1'b1;

    for (int st = 0; st < N; st++) begin
      for (int pat = 0; pat < (1 << N); pat++) begin
        @(negedge clk);
        build(N'(pat));
        start_off = SW'(st);
        line_vld = 1'b1;
        model(st);
        @(posedge clk);
        #1;
        // R2 R3 R4 R8 window placement
        chk("R4 win", win_o, ewin);
        // R5 valid bits
        chk("R5 vld", N*32'(vld_o), N*32'(evld));
        // R1 compressed flags
        chk("R1 cmp", N*32'(cmp_o), N*32'(ecmp));
        // R6 count
        chk("R6 cnt", N*32'(cnt_o), N*32'(ecnt));
        // R7 resume
        chk("R7 resume", N*32'(resume_o), N*32'(eres));
      end
    end

    @(negedge clk);
    line_vld = 1'b0;
    build(8'h5a);
    #1;
    // R9 outputs hold until the edge
    chk("R9 hold cnt", N*32'(cnt_o), N*32'(ecnt));
    chk("R9 hold win", win_o, ewin);
    @(posedge clk);
    #1;
    // R9 idle cycle clears outputs
    chk("R9 idle vld", N*32'(vld_o), '0);
    chk("R9 idle cnt", N*32'(cnt_o), '0);
    chk("R9 idle win", win_o, '0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule